// File: doc/BRIEF.md
# Timer Register Slave with Coherent 64-bit Count Read

This block is the register interface of a cascaded timer that runs either as one 64-bit counter or as two 32-bit halves. Software reaches it through a plain strobe bus: a read strobe, a write strobe, a byte address, 32-bit write data and registered read data. The counting datapath sits outside the block. It supplies the live low and high count words and a status bit. In return it receives the period words, the control and global control fields, the emulation bits, and a one-cycle load pulse with its data whenever software writes a count word.

In 64-bit mode a read of the low count word also captures the high count word in a shadow register. The next read of the high word returns that captured value, so a count read as two words stays consistent while the counter keeps running. While a half of the timer is active, the block protects its configuration and lets through only the enable-mode fields and the two soft-reset bits. A half is active when it is out of soft reset and its enable mode is nonzero.

Top module: `tmr_regfile`

## Requirements
- R1: The block decodes byte offsets 0x00 identification, 0x04 emulation, 0x10 low count, 0x14 high count, 0x18 low period, 0x1C high period, 0x20 control and 0x24 global control. A read of any other offset returns 0, and a write to any other offset changes nothing.
- R2: The identification word always reads 0x00010701 (type 0x01 in bits 22:16, class 0x07 in bits 15:8, revision 0x01 in bits 7:0), and writes to it are ignored.
- R3: The control word holds the upper-half enable mode in bits 23:22, clock select in bit 8, lower-half enable mode in bits 7:6, pulse width in bits 5:4, clock/pulse mode in bit 3, input invert in bit 2 and output invert in bit 1. Bit 0 reads the status input and cannot be written. All other bits read 0.
- R4: The global control word holds the prescale count in bits 15:12, the prescale period in bits 11:8, the mode in bits 3:2 (00 = 64-bit, 01 = two independent halves, 11 = chained), the upper-half run bit in bit 1 and the lower-half run bit in bit 0 (1 = out of soft reset). All other bits read 0.
- R5: The emulation word holds a free bit in bit 0 and a soft bit in bit 1, and all other bits read 0. It can be written at any time.
- R6: A write to the low or high count word that is not locked raises the matching load output for exactly one cycle and presents the written value on the load data. A read of a count word returns the live count input.
- R7: In mode 00, a read of the low count word captures the high count input. The next read of the high count word returns the captured value, even if the high count input has changed since.
- R8: In any mode other than 00, a read of the high count word returns the live high count input.
- R9: Writes to the low count and low period words are ignored while the lower half is active. Writes to the high count and high period words are ignored while the upper half is active. When the mode is not 01, they are also ignored while the lower half is active.
- R10: While either half is active, a write to the control or global control word updates only the two enable-mode fields and the two run bits. The lock is judged on the state before the write.
- R11: Read data is updated on the clock edge that samples the read strobe and holds its value in every cycle without a read strobe.
- R12: After reset, all stored fields, the outputs and the read data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | AW | Byte offset of the word accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| cnt_lo_in | input | 32 | Live low count from the datapath |
| cnt_hi_in | input | 32 | Live high count from the datapath |
| tstat | input | 1 | Timer status bit from the datapath |
| ld_lo | output | 1 | One-cycle load pulse for the low count |
| ld_hi | output | 1 | One-cycle load pulse for the high count |
| ld_data | output | 32 | Value to load into the count |
| prd_lo | output | 32 | Low period word |
| prd_hi | output | 32 | High period word |
| enmode_lo | output | 2 | Lower-half enable mode |
| enmode_hi | output | 2 | Upper-half enable mode |
| clk_sel | output | 1 | Clock source select |
| pulse_w | output | 2 | Output pulse width |
| clk_mode | output | 1 | Clock/pulse output mode |
| inv_in | output | 1 | Invert timer input |
| inv_out | output | 1 | Invert timer output |
| psc_cnt | output | 4 | Prescale count field |
| psc_prd | output | 4 | Prescale period field |
| tmode | output | 2 | Timer mode |
| run_lo | output | 1 | Lower half out of soft reset |
| run_hi | output | 1 | Upper half out of soft reset |
| emu_free | output | 1 | Emulation free bit |
| emu_soft | output | 1 | Emulation soft bit |

## Verification
The assertions check on every cycle that locked period and count writes leave the period words unchanged and raise no load pulse. They also check that the shadow holds the high count seen at the last low-count read, that the mode stays frozen under a global control write while active, that the run bits always follow a global control write, that reserved offsets read zero, and that read data holds when there is no read strobe. Only the bench scenarios can show the end-to-end behaviour seen by software: the exact bit layout of each word, the identification value, a coherent low/high pair while the high input moves, the direct reads in split mode, and the split lock, where the lower period stays writable while only the upper half runs.

// File: rtl/tmr_regfile.sv
module tmr_regfile #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic [31:0]   cnt_lo_in,
  input  logic [31:0]   cnt_hi_in,
  input  logic          tstat,
  output logic          ld_lo,
  output logic          ld_hi,
  output logic [31:0]   ld_data,
  output logic [31:0]   prd_lo,
  output logic [31:0]   prd_hi,
  output logic [1:0]    enmode_lo,
  output logic [1:0]    enmode_hi,
  output logic          clk_sel,
  output logic [1:0]    pulse_w,
  output logic          clk_mode,
  output logic          inv_in,
  output logic          inv_out,
  output logic [3:0]    psc_cnt,
  output logic [3:0]    psc_prd,
  output logic [1:0]    tmode,
  output logic          run_lo,
  output logic          run_hi,
  output logic          emu_free,
  output logic          emu_soft
);

  localparam logic [AW-1:0] A_ID    = AW'('h00);
  localparam logic [AW-1:0] A_EMU   = AW'('h04);
  localparam logic [AW-1:0] A_CNTLO = AW'('h10);
  localparam logic [AW-1:0] A_CNTHI = AW'('h14);
  localparam logic [AW-1:0] A_PRDLO = AW'('h18);
  localparam logic [AW-1:0] A_PRDHI = AW'('h1C);
  localparam logic [AW-1:0] A_CTL   = AW'('h20);
  localparam logic [AW-1:0] A_GCTL  = AW'('h24);
  localparam logic [31:0]   ID_WORD = 32'h0001_0701;

  logic [31:0] shadow, rmux;
  logic        lo_act, hi_act, any_act, hi_lock, rsv;

  assign lo_act  = run_lo && (enmode_lo != 2'b00);
  assign hi_act  = run_hi && (enmode_hi != 2'b00);
  assign any_act = lo_act || hi_act;
  assign hi_lock = hi_act || ((tmode != 2'b01) && lo_act);
  assign rsv     = !(addr inside {A_ID, A_EMU, A_CNTLO, A_CNTHI, A_PRDLO, A_PRDHI, A_CTL, A_GCTL});

  wire we_cntlo = wr_en && addr == A_CNTLO;
  wire we_cnthi = wr_en && addr == A_CNTHI;
  wire we_prdlo = wr_en && addr == A_PRDLO;
  wire we_prdhi = wr_en && addr == A_PRDHI;
  wire we_ctl   = wr_en && addr == A_CTL;
  wire we_gctl  = wr_en && addr == A_GCTL;
  wire we_emu   = wr_en && addr == A_EMU;

  always_comb begin
    case (addr)
      A_ID:    rmux = ID_WORD;
      A_EMU:   rmux = {30'b0, emu_soft, emu_free};
      A_CNTLO: rmux = cnt_lo_in;
      A_CNTHI: rmux = (tmode == 2'b00) ? shadow : cnt_hi_in;
      A_PRDLO: rmux = prd_lo;
      A_PRDHI: rmux = prd_hi;
      A_CTL:   rmux = {8'b0, enmode_hi, 13'b0, clk_sel, enmode_lo, pulse_w, clk_mode, inv_in, inv_out, tstat};
      A_GCTL:  rmux = {16'b0, psc_cnt, psc_prd, 4'b0, tmode, run_hi, run_lo};
      default: rmux = 32'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0; shadow <= '0;
      ld_lo <= 1'b0; ld_hi <= 1'b0; ld_data <= '0;
      prd_lo <= '0; prd_hi <= '0;
      enmode_lo <= '0; enmode_hi <= '0; clk_sel <= 1'b0; pulse_w <= '0;
      clk_mode <= 1'b0; inv_in <= 1'b0; inv_out <= 1'b0;
      psc_cnt <= '0; psc_prd <= '0; tmode <= '0; run_lo <= 1'b0; run_hi <= 1'b0;
      emu_free <= 1'b0; emu_soft <= 1'b0;
    end else begin
      ld_lo <= 1'b0;
      ld_hi <= 1'b0;
      if (rd_en) rdata <= rmux;
      if (rd_en && addr == A_CNTLO) shadow <= cnt_hi_in;
      if (we_cntlo && !lo_act) begin ld_lo <= 1'b1; ld_data <= wdata; end
      if (we_cnthi && !hi_lock) begin ld_hi <= 1'b1; ld_data <= wdata; end
      if (we_prdlo && !lo_act) prd_lo <= wdata;
      if (we_prdhi && !hi_lock) prd_hi <= wdata;
      if (we_emu) begin emu_free <= wdata[0]; emu_soft <= wdata[1]; end
      if (we_ctl) begin
        enmode_lo <= wdata[7:6];
        enmode_hi <= wdata[23:22];
        if (!any_act) begin
          clk_sel <= wdata[8]; pulse_w <= wdata[5:4]; clk_mode <= wdata[3];
          inv_in <= wdata[2]; inv_out <= wdata[1];
        end
      end
      if (we_gctl) begin
        run_lo <= wdata[0];
        run_hi <= wdata[1];
        if (!any_act) begin
          tmode <= wdata[3:2]; psc_prd <= wdata[11:8]; psc_cnt <= wdata[15:12];
        end
      end
    end
  end

  a_r9_prd_lo_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_PRDLO && lo_act) |=> $stable(prd_lo));
  a_r9_prd_hi_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_PRDHI && hi_lock) |=> $stable(prd_hi));
  a_r6_no_load_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CNTLO && lo_act) |=> !ld_lo);
  a_r7_shadow_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_CNTLO) |=> shadow == $past(cnt_hi_in));
  a_r10_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_GCTL && any_act) |=> $stable(tmode));
  a_r10_run_bits_open: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_GCTL) |=> (run_lo == $past(wdata[0]) && run_hi == $past(wdata[1])));
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rsv) |=> rdata == 32'b0);
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

endmodule

// File: tb/tb_tmr_regfile.sv
module tb_tmr_regfile;
  logic clk = 1'b0, rst_n = 1'b0, rd_en = 1'b0, wr_en = 1'b0, tstat = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata, cnt_lo_in = '0, cnt_hi_in = '0, ld_data, prd_lo, prd_hi;
  logic ld_lo, ld_hi, clk_sel, clk_mode, inv_in, inv_out, run_lo, run_hi, emu_free, emu_soft;
  logic [1:0] enmode_lo, enmode_hi, pulse_w, tmode;
  logic [3:0] psc_cnt, psc_prd;
  int checks = 0, fails = 0;
  logic seen_lo, seen_hi;
  logic [31:0] seen_data, v;

  always #2 clk = ~clk;

  tmr_regfile #(.AW(8)) dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
    seen_lo = ld_lo; seen_hi = ld_hi; seen_data = ld_data;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset;
    rd(8'h20, v); chk("R12 ctl", v, 0);
    rd(8'h24, v); chk("R12 gctl", v, 0);
    rd(8'h18, v); chk("R12 prd_lo", v, 0);
    rd(8'h04, v); chk("R12 emu", v, 0);
    chk("R12 outputs", {ld_lo, ld_hi, run_lo, run_hi, tmode}, 0);
  endtask

  task automatic t_id;
    rd(8'h00, v); chk("R2 id", v, 32'h0001_0701);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); chk("R2 id read-only", v, 32'h0001_0701);
    @(negedge clk); @(negedge clk);
    chk("R11 rdata held", rdata, 32'h0001_0701);
  endtask

  task automatic t_reserved;
    wr(8'h08, 32'hDEAD_BEEF);
    wr(8'h28, 32'h0000_00FF);
    rd(8'h08, v); chk("R1 reserved 08 reads 0", v, 0);
    rd(8'h0C, v); chk("R1 reserved 0C reads 0", v, 0);
    rd(8'h18, v); chk("R1 reserved write no effect prd_lo", v, 0);
    rd(8'h24, v); chk("R1 reserved write no effect gctl", v, 0);
  endtask

  task automatic t_emu;
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, v); chk("R5 emu", v, 32'h3);
    chk("R5 emu outputs", {emu_soft, emu_free}, 2'b11);
    wr(8'h04, 32'h1);
    rd(8'h04, v); chk("R5 emu free only", v, 32'h1);
  endtask

  task automatic t_ctl;
    tstat = 1'b1;
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, v); chk("R3 ctl layout", v, 32'h00C0_01FF);
    wr(8'h20, 32'h0000_0000);
    rd(8'h20, v); chk("R3 status read-only", v, 32'h1);
    tstat = 1'b0;
    rd(8'h20, v); chk("R3 status follows input", v, 0);
  endtask

  task automatic t_gctl;
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h24, v); chk("R4 gctl layout", v, 32'h0000_FF0F);
    chk("R4 gctl fields", {psc_cnt, psc_prd, tmode, run_hi, run_lo}, 12'hFFF);
    wr(8'h24, 32'h0);
    rd(8'h24, v); chk("R4 gctl cleared", v, 0);
  endtask

  task automatic t_count;
    wr(8'h10, 32'h0000_1234);
    chk("R6 ld_lo pulse", {seen_lo, seen_hi}, 2'b10);
    chk("R6 ld data lo", seen_data, 32'h0000_1234);
    @(negedge clk); chk("R6 ld_lo single cycle", ld_lo, 0);
    wr(8'h14, 32'hABCD_0000);
    chk("R6 ld_hi pulse", {seen_lo, seen_hi}, 2'b01);
    chk("R6 ld data hi", seen_data, 32'hABCD_0000);
    cnt_lo_in = 32'h1111_2222;
    rd(8'h10, v); chk("R6 live low count", v, 32'h1111_2222);
  endtask

  task automatic t_coherent;
    cnt_hi_in = 32'hAAAA_0001;
    rd(8'h10, v);
    cnt_hi_in = 32'hBBBB_0002;
    rd(8'h14, v); chk("R7 coherent high", v, 32'hAAAA_0001);
    wr(8'h24, 32'h4);
    rd(8'h10, v);
    cnt_hi_in = 32'hCCCC_0003;
    rd(8'h14, v); chk("R8 split live high", v, 32'hCCCC_0003);
    wr(8'h24, 32'hC);
    cnt_hi_in = 32'hDDDD_0004;
    rd(8'h14, v); chk("R8 chained live high", v, 32'hDDDD_0004);
    wr(8'h24, 32'h0);
  endtask

  task automatic t_lock_joined;
    wr(8'h24, 32'h3);
    wr(8'h20, 32'h80);
    wr(8'h18, 32'h5);
    rd(8'h18, v); chk("R9 low period locked", v, 0);
    wr(8'h1C, 32'h6);
    rd(8'h1C, v); chk("R9 high period locked by low half when joined", v, 0);
    wr(8'h10, 32'h7);
    chk("R9 no load when locked", {seen_lo, seen_hi}, 2'b00);
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, v); chk("R10 ctl only enables", v, 32'h00C0_00C0);
    wr(8'h24, 32'h0000_FF07);
    rd(8'h24, v); chk("R10 gctl only run bits", v, 32'h3);
    wr(8'h20, 32'h0);
    wr(8'h24, 32'h0);
    rd(8'h24, v); chk("R10 unlocked cleanup", v, 0);
  endtask

  task automatic t_lock_split;
    wr(8'h24, 32'h7);
    wr(8'h20, 32'h0080_0000);
    wr(8'h18, 32'h55);
    rd(8'h18, v); chk("R9 split low period open", v, 32'h55);
    wr(8'h1C, 32'h66);
    rd(8'h1C, v); chk("R9 split high period locked", v, 0);
    wr(8'h14, 32'h77);
    chk("R9 split no high load", {seen_lo, seen_hi}, 2'b00);
    wr(8'h20, 32'h0);
    wr(8'h24, 32'h0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset; t_id; t_reserved; t_emu; t_ctl; t_gctl;
    t_count; t_coherent; t_lock_joined; t_lock_split;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule